// File: doc/BRIEF.md
# Branch-with-link execution unit

This unit is the slice of a 32-bit processor's execute stage that handles calls. It holds the program counter and looks at each instruction word offered to it. It claims the four call forms and ignores every other opcode, so a neighbouring unit can pick those up. For a claimed call whose condition holds, it loads the computed target into the program counter and writes the return address (the old pc plus 4) to the link register. A claimed call whose condition fails only steps the pc by 4.

There are four ways to form the target. Two add an immediate to the pc: one immediate is a word count, the other is a byte count. One adds a word-scaled immediate to a base register. One adds two registers. The unit drives the register numbers to the register file and gets the register values back in the same cycle. If a taken target is not a multiple of four, the unit raises a one-cycle fault and changes neither the pc nor the link register. The condition flags are never altered.

Top module: `link_branch_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes `RESET_PC` and `out_valid`, `lr_we` and `fault` become 0.
- R2: Opcode 7'h14 in bits [6:0] takes its condition code from bits [10:7]. Bits [31:11] hold a signed 21-bit word count. The target is pc + 4 × count.
- R3: Opcode 7'h15 has no condition and is always taken. Bits [31:8] hold a signed 24-bit byte offset, used unscaled, and the target is pc + offset. The unit claims this form only when bit 7 is 0. With bit 7 set, the word is not claimed.
- R4: Opcode 7'h16 takes its condition from bits [10:7] and its base register number from bits [20:16]. It assembles a signed 16-bit word count from bits [31:21] (upper 11 bits) and bits [15:11] (lower 5 bits). The target is base + 4 × count.
- R5: Opcode 7'h17 takes its condition from bits [10:7], its base register number from bits [20:16] and its offset register number from bits [25:21]. The target is base + offset register. Bits [31:26] and [15:11] have no effect.
- R6: For a taken, aligned call, on the next rising edge `pc` becomes the target, `lr_wdata` becomes the old pc + 4, and `lr_we` goes high for exactly one cycle.
- R7: For a claimed call whose condition fails, `pc` advances by 4 and `lr_we` stays low.
- R8: The condition codes are tested against flags = {N,Z,C,V} (bit 3 down to bit 0), as follows:
  - 0 eq: Z
  - 1 ne: !Z
  - 2: C
  - 3: !C
  - 4: N
  - 5: !N
  - 6: V
  - 7: !V
  - 8: C&!Z
  - 9: !C|Z
  - A: N==V
  - B: N!=V
  - C: !Z&(N==V)
  - D: Z|(N!=V)
  - E: always
  - F: never
- R9: A taken call whose target has bits [1:0] not equal to zero gives a one-cycle `fault` pulse. `pc` is held and `lr_we` stays low.
- R10: When `in_valid` is low, or the opcode is outside 7'h14..7'h17, `out_valid`, `lr_we` and `fault` stay low and `pc` is held.
- R11: `out_valid` is high for exactly the one cycle after each claimed instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| flags | input | 4 | Status from last comparison {N,Z,C,V} |
| base_rdata | input | 32 | Value of the register named by base_idx |
| offs_rdata | input | 32 | Value of the register named by offs_idx |
| base_idx | output | 5 | Base register number, from instr[20:16] |
| offs_idx | output | 5 | Offset register number, from instr[25:21] |
| out_valid | output | 1 | A call was claimed in the previous cycle |
| pc | output | 32 | Program counter |
| lr_we | output | 1 | Link register write strobe |
| lr_wdata | output | 32 | Return address for the link register |
| fault | output | 1 | Misaligned target pulse |

## Verification
The bench builds the unit with `RESET_PC` at 32'h0001_0000 and `ALIGN_CHECK` at 1. With the pc starting well above zero, backward offsets can be exercised without wrapping. The alignment fault path is present in this build, so odd byte offsets and misaligned register sums can be tested against the hold-and-pulse behaviour. The largest positive word offset also stays inside the address space, so the sign-extension boundary of each immediate can be checked.

// File: rtl/blu_pkg.sv
package blu_pkg;

   localparam logic [6:0] OPC_BL_COND = 7'h14;
   localparam logic [6:0] OPC_BL_WIDE = 7'h15;
   localparam logic [6:0] OPC_BLX_IMM = 7'h16;
   localparam logic [6:0] OPC_BLX_REG = 7'h17;

   localparam int FL_V = 0;
   localparam int FL_C = 1;
   localparam int FL_Z = 2;
   localparam int FL_N = 3;

   typedef enum logic [3:0] {
      CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
      CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
      CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
      CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
   } cc_e;

   typedef struct packed {
      logic        mine;
      logic        conditional;
      logic [3:0]  cc;
      logic        rel_base;
      logic        reg_off;
      logic [31:0] imm;
   } dec_t;

endpackage

// File: rtl/blu_decode.sv
module blu_decode
   import blu_pkg::*;
#(
   parameter int IDX_W = 5
) (
   input  logic [31:0]      instr,
   output dec_t             dec,
   output logic [IDX_W-1:0] base_idx,
   output logic [IDX_W-1:0] offs_idx
);
   logic [15:0] split_off;

   assign base_idx  = instr[16 +: IDX_W];
   assign offs_idx  = instr[21 +: IDX_W];
   assign split_off = {instr[31:21], instr[15:11]};

   always_comb begin
      dec             = '0;
      dec.cc          = instr[10:7];
      unique case (instr[6:0])
         OPC_BL_COND: begin
            dec.mine        = 1'b1;
            dec.conditional = 1'b1;
            dec.imm         = {{9{instr[31]}}, instr[31:11], 2'b00};
         end
         OPC_BL_WIDE: begin
            dec.mine        = ~instr[7];
            dec.imm         = {{8{instr[31]}}, instr[31:8]};
         end
         OPC_BLX_IMM: begin
            dec.mine        = 1'b1;
            dec.conditional = 1'b1;
            dec.rel_base    = 1'b1;
            dec.imm         = {{14{split_off[15]}}, split_off, 2'b00};
         end
         OPC_BLX_REG: begin
            dec.mine        = 1'b1;
            dec.conditional = 1'b1;
            dec.rel_base    = 1'b1;
            dec.reg_off     = 1'b1;
         end
         default: dec.mine = 1'b0;
      endcase
   end
endmodule

// File: rtl/blu_cond.sv
module blu_cond
   import blu_pkg::*;
(
   input  logic [3:0] cc,
   input  logic [3:0] flags,
   output logic       pass
);
   logic n, z, c, v;
   assign n = flags[FL_N];
   assign z = flags[FL_Z];
   assign c = flags[FL_C];
   assign v = flags[FL_V];

   always_comb begin
      unique case (cc_e'(cc))
         CC_EQ: pass = z;
         CC_NE: pass = ~z;
         CC_CS: pass = c;
         CC_CC: pass = ~c;
         CC_MI: pass = n;
         CC_PL: pass = ~n;
         CC_VS: pass = v;
         CC_VC: pass = ~v;
         CC_HI: pass = c & ~z;
         CC_LS: pass = ~c | z;
         CC_GE: pass = (n == v);
         CC_LT: pass = (n != v);
         CC_GT: pass = ~z & (n == v);
         CC_LE: pass = z | (n != v);
         CC_AL: pass = 1'b1;
         default: pass = 1'b0;
      endcase
   end
endmodule

// File: rtl/blu_target.sv
module blu_target
   import blu_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter bit ALIGN_CHECK = 1'b1
) (
   input  logic [XLEN-1:0] pc,
   input  logic [XLEN-1:0] base_val,
   input  logic [XLEN-1:0] offs_val,
   input  dec_t            dec,
   output logic [XLEN-1:0] target,
   output logic            misaligned
);
   logic [XLEN-1:0] lhs, rhs;

   assign lhs    = dec.rel_base ? base_val : pc;
   assign rhs    = dec.reg_off  ? offs_val : dec.imm[XLEN-1:0];
   assign target = lhs + rhs;

   generate
      if (ALIGN_CHECK) begin : g_align
         assign misaligned = |target[1:0];
      end else begin : g_no_align
         assign misaligned = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/link_branch_unit.sv
module link_branch_unit
   import blu_pkg::*;
#(
   parameter int              XLEN        = 32,
   parameter int              IDX_W       = 5,
   parameter logic [XLEN-1:0] RESET_PC    = '0,
   parameter bit              ALIGN_CHECK = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [31:0]      instr,
   input  logic [3:0]       flags,
   input  logic [XLEN-1:0]  base_rdata,
   input  logic [XLEN-1:0]  offs_rdata,
   output logic [IDX_W-1:0] base_idx,
   output logic [IDX_W-1:0] offs_idx,
   output logic             out_valid,
   output logic [XLEN-1:0]  pc,
   output logic             lr_we,
   output logic [XLEN-1:0]  lr_wdata,
   output logic             fault
);
   localparam logic [XLEN-1:0] STEP = XLEN'(4);

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("link_branch_unit: XLEN must be 32 for this encoding");
      end
      if (IDX_W != 5) begin : g_bad_idx
         $error("link_branch_unit: IDX_W must be 5 for this encoding");
      end
   endgenerate

   dec_t            dec;
   logic            cond_ok, take, misaligned;
   logic [XLEN-1:0] target;

   blu_decode #(.IDX_W(IDX_W)) u_dec (
      .instr(instr), .dec(dec), .base_idx(base_idx), .offs_idx(offs_idx)
   );

   blu_cond u_cond (.cc(dec.cc), .flags(flags), .pass(cond_ok));

   blu_target #(.XLEN(XLEN), .ALIGN_CHECK(ALIGN_CHECK)) u_tgt (
      .pc(pc), .base_val(base_rdata), .offs_val(offs_rdata), .dec(dec),
      .target(target), .misaligned(misaligned)
   );

   assign take = ~dec.conditional | cond_ok;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc        <= RESET_PC;
         out_valid <= 1'b0;
         lr_we     <= 1'b0;
         lr_wdata  <= '0;
         fault     <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         lr_we     <= 1'b0;
         fault     <= 1'b0;
         if (in_valid && dec.mine) begin
            out_valid <= 1'b1;
            if (!take) begin
               pc <= pc + STEP;
            end else if (misaligned) begin
               fault <= 1'b1;
            end else begin
               pc       <= target;
               lr_we    <= 1'b1;
               lr_wdata <= pc + STEP;
            end
         end
      end
   end
endmodule

// File: rtl/blu_checker.sv
module blu_checker #(
   parameter int XLEN        = 32,
   parameter bit ALIGN_CHECK = 1'b1
) (
   input logic            clk,
   input logic            rst,
   input logic            out_valid,
   input logic [XLEN-1:0] pc,
   input logic            lr_we,
   input logic [XLEN-1:0] lr_wdata,
   input logic            fault
);
   p_link_is_ret_r6: assert property (@(posedge clk) disable iff (rst)
      lr_we |-> (lr_wdata == $past(pc) + XLEN'(4)));

   p_fault_holds_pc_r9: assert property (@(posedge clk) disable iff (rst)
      fault |-> (pc == $past(pc)));

   p_fault_no_link_r9: assert property (@(posedge clk) disable iff (rst)
      !(fault && lr_we));

   p_idle_holds_pc_r10: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> (pc == $past(pc)));

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> (!lr_we && !fault));

   p_fallthru_step_r7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !lr_we && !fault) |-> (pc == $past(pc) + XLEN'(4)));

   generate
      if (ALIGN_CHECK) begin : g_al
         p_target_aligned_r9: assert property (@(posedge clk) disable iff (rst)
            lr_we |-> (pc[1:0] == 2'b00));
      end
   endgenerate
endmodule

bind link_branch_unit blu_checker #(.XLEN(XLEN), .ALIGN_CHECK(ALIGN_CHECK)) u_chk (
   .clk(clk), .rst(rst), .out_valid(out_valid), .pc(pc),
   .lr_we(lr_we), .lr_wdata(lr_wdata), .fault(fault)
);

// File: tb/sim_link_branch_unit.sv
module sim_link_branch_unit;
   localparam logic [31:0] RPC = 32'h0001_0000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [3:0]  flags = '0;
   logic [31:0] base_rdata, offs_rdata;
   logic [4:0]  base_idx, offs_idx;
   logic        out_valid, lr_we, fault;
   logic [31:0] pc, lr_wdata;
   logic [31:0] rf [32];
   int checks = 0;
   int errors = 0;
   logic [31:0] exp_pc;

   always #4 clk = ~clk;

   assign base_rdata = rf[base_idx];
   assign offs_rdata = rf[offs_idx];

   link_branch_unit #(.RESET_PC(RPC), .ALIGN_CHECK(1'b1)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .flags(flags),
      .base_rdata(base_rdata), .offs_rdata(offs_rdata),
      .base_idx(base_idx), .offs_idx(offs_idx), .out_valid(out_valid),
      .pc(pc), .lr_we(lr_we), .lr_wdata(lr_wdata), .fault(fault)
   );

   function automatic logic [31:0] e14(input logic [3:0] cc, input logic [20:0] off);
      return {off, cc, 7'h14};
   endfunction
   function automatic logic [31:0] e15(input logic [23:0] off);
      return {off, 1'b0, 7'h15};
   endfunction
   function automatic logic [31:0] e16(input logic [3:0] cc, input logic [4:0] b, input logic [15:0] off);
      return {off[15:5], b, off[4:0], cc, 7'h16};
   endfunction
   function automatic logic [31:0] e17(input logic [3:0] cc, input logic [4:0] b, input logic [4:0] o);
      return {6'h00, o, b, 5'h00, cc, 7'h17};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [31:0] ins, input logic [3:0] fl, input logic v);
      instr = ins; flags = fl; in_valid = v;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic exp_taken(input string tag, input logic [31:0] tgt);
      chk({tag, " pc"}, pc, tgt);
      chk({tag, " lr_we"}, {31'b0, lr_we}, 32'd1);
      chk({tag, " lr_wdata"}, lr_wdata, exp_pc + 32'd4);
      chk({tag, " out_valid R11"}, {31'b0, out_valid}, 32'd1);
      chk({tag, " fault"}, {31'b0, fault}, 32'd0);
      exp_pc = tgt;
   endtask

   task automatic exp_fall(input string tag);
      chk({tag, " pc+4"}, pc, exp_pc + 32'd4);
      chk({tag, " lr_we"}, {31'b0, lr_we}, 32'd0);
      chk({tag, " out_valid R11"}, {31'b0, out_valid}, 32'd1);
      exp_pc = exp_pc + 32'd4;
   endtask

   task automatic exp_fault(input string tag);
      chk({tag, " pc held"}, pc, exp_pc);
      chk({tag, " fault"}, {31'b0, fault}, 32'd1);
      chk({tag, " lr_we"}, {31'b0, lr_we}, 32'd0);
   endtask

   task automatic exp_idle(input string tag);
      chk({tag, " pc held"}, pc, exp_pc);
      chk({tag, " out_valid"}, {31'b0, out_valid}, 32'd0);
      chk({tag, " lr_we"}, {31'b0, lr_we}, 32'd0);
      chk({tag, " fault"}, {31'b0, fault}, 32'd0);
   endtask

   task automatic t_reset;
      chk("R1 pc", pc, RPC);
      chk("R1 out_valid", {31'b0, out_valid}, 32'd0);
      chk("R1 lr_we", {31'b0, lr_we}, 32'd0);
      chk("R1 fault", {31'b0, fault}, 32'd0);
      exp_pc = RPC;
   endtask

   task automatic t_cond_imm;
      issue(e14(4'h0, -21'sd5), 4'b0100, 1'b1);
      exp_taken("R2 eq back R6", exp_pc - 32'd20);
      issue(e14(4'h0, 21'd3), 4'b0000, 1'b1);
      exp_fall("R7 eq fails");
      issue(e14(4'hE, 21'h0FFFFF), 4'b0000, 1'b1);
      exp_taken("R2 max fwd", exp_pc + 32'd4194300);
      issue(e14(4'hE, 21'h100000), 4'b0000, 1'b1);
      exp_taken("R2 min back", exp_pc - 32'd4194304);
   endtask

   task automatic t_conds;
      issue(e14(4'h1, 21'd2), 4'b0000, 1'b1); exp_taken("R8 ne", exp_pc + 32'd8);
      issue(e14(4'hA, 21'd2), 4'b1001, 1'b1); exp_taken("R8 ge", exp_pc + 32'd8);
      issue(e14(4'hB, 21'd2), 4'b1000, 1'b1); exp_taken("R8 lt", exp_pc + 32'd8);
      issue(e14(4'hB, 21'd2), 4'b1001, 1'b1); exp_fall("R8 lt fails");
      issue(e14(4'h8, 21'd2), 4'b0010, 1'b1); exp_taken("R8 hi", exp_pc + 32'd8);
      issue(e14(4'h8, 21'd2), 4'b0110, 1'b1); exp_fall("R8 hi fails");
      issue(e14(4'hC, 21'd2), 4'b0100, 1'b1); exp_fall("R8 gt fails");
      issue(e14(4'hF, 21'd2), 4'b1111, 1'b1); exp_fall("R8 never");
   endtask

   task automatic t_wide;
      issue(e15(24'h000010), 4'b0000, 1'b1);
      exp_taken("R3 wide fwd", exp_pc + 32'd16);
      issue(e15(-24'sd8), 4'b0000, 1'b1);
      exp_taken("R3 wide back", exp_pc - 32'd8);
      issue(e15(24'h000003), 4'b0000, 1'b1);
      exp_fault("R3 R9 odd offset");
      issue(e15(24'h000010) | 32'h80, 4'b0000, 1'b1);
      exp_idle("R3 bit7 set");
   endtask

   task automatic t_base_imm;
      rf[3] = 32'h0002_0000;
      issue(e16(4'hE, 5'd3, 16'hFFFD), 4'b0000, 1'b1);
      exp_taken("R4 base-12", 32'h0002_0000 - 32'd12);
      issue(e16(4'hE, 5'd3, 16'h0421), 4'b0000, 1'b1);
      exp_taken("R4 split", 32'h0002_0000 + 32'h1084);
      rf[4] = 32'h0002_0002;
      issue(e16(4'hE, 5'd4, 16'h0000), 4'b0000, 1'b1);
      exp_fault("R4 R9 odd base");
      issue(32'h0, 4'b0000, 1'b0);
      exp_idle("R9 pulse ends");
   endtask

   task automatic t_reg;
      rf[2] = 32'h0003_0000; rf[5] = 32'h40;
      issue(e17(4'hE, 5'd2, 5'd5) | 32'hFC00_F800, 4'b0000, 1'b1);
      exp_taken("R5 reg sum", 32'h0003_0040);
      issue(e17(4'h0, 5'd2, 5'd5), 4'b0000, 1'b1);
      exp_fall("R5 R7 fails");
      rf[5] = 32'h41;
      issue(e17(4'hE, 5'd2, 5'd5), 4'b0000, 1'b1);
      exp_fault("R5 R9 misaligned");
   endtask

   task automatic t_other;
      issue(32'h0000_0013, 4'b0100, 1'b1);
      exp_idle("R10 foreign opcode");
      issue(e14(4'hE, 21'd4), 4'b0000, 1'b0);
      exp_idle("R10 valid low");
      issue(32'h0000_0018, 4'b0100, 1'b1);
      exp_idle("R10 opcode 18");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 32; i++) rf[i] = 32'h0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_cond_imm();
      t_conds();
      t_wide();
      t_base_imm();
      t_reg();
      t_other();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule